// File: doc/BRIEF.md
# Saturating Add/Subtract Unit with Doubling

This block performs signed arithmetic on 32-bit two's-complement words. When the true result does not fit, the output is clamped to the nearest representable limit instead of wrapping. It has four operations. Two are a plain saturating add and a plain saturating subtract. The other two first double the second operand (`in_b`), clamping that doubled value if it overflows, and then add it to or subtract it from the first operand (`in_a`), clamping again if needed. A saturation indicator comes out with every result. It is high when either clamping stage fired, and the surrounding datapath can OR it into a sticky overflow flag.

Operands enter through a valid/ready stream and the result leaves through another. A single output register sits between them, so a result appears one cycle after its operands are accepted. The upstream side may present a new operation only while `in_ready` is high. `in_ready` is high when the output register is empty, or when it is being drained in the same cycle. If `out_ready` is held low while `out_valid` is high, the result and the indicator stay frozen and no new operand is taken. Because a drain and a load can happen in the same cycle, back-to-back operation runs at one result per clock.

Top module: `qsat_unit`

## Requirements
- R1: Operation code 2'b00 returns the sum `in_a + in_b`. If the operands have the same sign and the 32-bit sum has the opposite sign, the operation overflows. Otherwise the wrapped sum is returned unchanged and `out_sat` is 0.
- R2: If an add overflows, the result is 32'h7FFFFFFF when the wrapped sum has bit 31 set and 32'h80000000 when it has bit 31 clear, and `out_sat` is 1.
- R3: Operation code 2'b01 returns `in_a - in_b`. It overflows only when the operands differ in sign and the difference's sign differs from `in_a`. On overflow the result is clamped by the same rule as R2 and `out_sat` is 1. Otherwise the wrapped difference is returned and `out_sat` is 0.
- R4: Operation codes 2'b10 and 2'b11 first double `in_b`. If doubling changes the sign (bits 31 and 30 differ), the doubled value becomes 32'h7FFFFFFF for a non-negative `in_b` and 32'h80000000 for a negative `in_b`, and `out_sat` is 1 for that operation.
- R5: Code 2'b10 then saturating-adds the doubled value to `in_a`, and code 2'b11 saturating-subtracts it from `in_a`, using the R1–R3 rules. `out_sat` is the OR of both stages.
- R6: After reset, `out_valid` is 0 and `in_ready` is 1.
- R7: An operation is accepted on a clock edge where `in_valid` and `in_ready` are both 1. Its result is on `out_result`/`out_sat` with `out_valid` high from the next cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_result`, `out_sat` and `out_valid` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and operation code are presented |
| in_ready | output | 1 | Unit can accept an operation this cycle |
| in_op | input | 2 | 00 add, 01 subtract, 10 doubling add, 11 doubling subtract |
| in_a | input | 32 | First operand (minuend for subtraction) |
| in_b | input | 32 | Second operand (doubled in codes 10 and 11) |
| out_valid | output | 1 | Result register holds an undelivered result |
| out_ready | input | 1 | Downstream accepts the result this cycle |
| out_result | output | 32 | Saturated result |
| out_sat | output | 1 | High when any saturation stage clamped |

## Verification
All arithmetic is resolved before the output register, so a wrong clamp decision or wrong limit value shows up on `out_result`/`out_sat` in the first cycle after acceptance. There is no hidden state that could defer the error. A mistake in the doubling stage is visible only for operands whose bits 31 and 30 differ, so the vectors include the exact boundary values on both sides of that condition. A faulty hold or ready term shows up as a changed result, or a lost or repeated result, within the one or two cycles of a stall.

// File: rtl/qsat_pkg.sv
package qsat_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_DADD = 2'b10,
    OP_DSUB = 2'b11
  } qsat_op_e;
endpackage

// File: rtl/qsat_double.sv
// Doubling stage: shifts the operand left by one, clamping on sign change.
module qsat_double #(
  parameter int W = 32
) (
  input  logic         en,
  input  logic [W-1:0] val,
  output logic [W-1:0] dbl,
  output logic         sat
);
  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  logic wraps;
  assign wraps = val[W-1] ^ val[W-2];

  always_comb begin
    if (!en) begin
      dbl = val;
      sat = 1'b0;
    end else if (wraps) begin
      dbl = val[W-1] ? NEG_LIM : POS_LIM;
      sat = 1'b1;
    end else begin
      dbl = {val[W-2:0], 1'b0};
      sat = 1'b0;
    end
  end
endmodule

// File: rtl/qsat_addsub.sv
// Signed add or subtract with clamping to the representable range.
module qsat_addsub #(
  parameter int W = 32
) (
  input  logic         sub,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         sat
);
  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] raw;
  logic         same_sign;
  logic         ovf;

  always_comb begin
    raw       = sub ? (a - b) : (a + b);
    same_sign = ~(a[W-1] ^ b[W-1]);
    // add needs equal signs, subtract needs differing signs
    ovf       = (sub ? ~same_sign : same_sign) & (raw[W-1] ^ a[W-1]);
    if (ovf) res = raw[W-1] ? POS_LIM : NEG_LIM;
    else     res = raw;
    sat = ovf;
  end
endmodule

// File: rtl/qsat_unit.sv
module qsat_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_sat
);
  import qsat_pkg::*;

  qsat_op_e     op;
  logic [W-1:0] b_dbl;
  logic         sat_dbl;
  logic [W-1:0] res_c;
  logic         sat_as;
  logic         load;

  assign op = qsat_op_e'(in_op);

  qsat_double #(.W(W)) u_dbl (
    .en  (op == OP_DADD || op == OP_DSUB),
    .val (in_b),
    .dbl (b_dbl),
    .sat (sat_dbl)
  );

  qsat_addsub #(.W(W)) u_as (
    .sub (op == OP_SUB || op == OP_DSUB),
    .a   (in_a),
    .b   (b_dbl),
    .res (res_c),
    .sat (sat_as)
  );

  assign in_ready = ~out_valid | out_ready;
  assign load     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_sat    <= 1'b0;
    end else begin
      if (load) begin
        out_valid  <= 1'b1;
        out_result <= res_c;
        out_sat    <= sat_dbl | sat_as;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/qsat_unit_chk.sv
module qsat_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [1:0]   in_op,
  input logic [W-1:0] in_b,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_result,
  input logic         out_sat
);
  logic [1:0] cap_op;
  logic       cap_dbl_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_op       <= 2'b00;
      cap_dbl_wrap <= 1'b0;
    end else if (in_valid && in_ready) begin
      cap_op       <= in_op;
      cap_dbl_wrap <= in_b[W-1] ^ in_b[W-2];
    end
  end

  // R7: an accepted operation yields a valid result next cycle
  a_r7_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R8: a stalled result stays put
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_sat)));

  // R8: no acceptance while stalled
  a_r8_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R2, R3: a clamped plain add/subtract lands on a range limit
  a_r2_limit_value: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sat && !cap_op[1]) |->
      (out_result == {1'b0, {(W-1){1'b1}}} || out_result == {1'b1, {(W-1){1'b0}}}));

  // R4: a doubling that changes sign always reports saturation
  a_r4_double_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_op[1] && cap_dbl_wrap) |-> out_sat);
endmodule

bind qsat_unit qsat_unit_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .in_b       (in_b),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_sat    (out_sat)
);

// File: tb/qsat_unit_tb.sv
module qsat_unit_tb;
  localparam int W = 32;
  localparam int NV = 17;
  // {op, a, b, expected result, expected sat}
  localparam logic [98:0] VEC [NV] = '{
    {2'b00, 32'h00000005, 32'h00000007, 32'h0000000C, 1'b0}, // R1
    {2'b00, 32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFF, 1'b1}, // R2
    {2'b00, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 1'b1}, // R2
    {2'b00, 32'hFFFFFFFF, 32'h80000001, 32'h80000000, 1'b0}, // R1
    {2'b01, 32'h0000000A, 32'h00000003, 32'h00000007, 1'b0}, // R3
    {2'b01, 32'h80000000, 32'h00000001, 32'h80000000, 1'b1}, // R3
    {2'b01, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b1}, // R3
    {2'b01, 32'h00000000, 32'h80000000, 32'h7FFFFFFF, 1'b1}, // R3
    {2'b10, 32'h00000001, 32'h00000003, 32'h00000007, 1'b0}, // R4
    {2'b10, 32'hFFFFFFF6, 32'h40000000, 32'h7FFFFFF5, 1'b1}, // R4
    {2'b10, 32'h00000000, 32'hBFFFFFFF, 32'h80000000, 1'b1}, // R4
    {2'b10, 32'h7FFFFFF0, 32'h00000010, 32'h7FFFFFFF, 1'b1}, // R5
    {2'b11, 32'h00000064, 32'h00000014, 32'h0000003C, 1'b0}, // R5
    {2'b11, 32'h00000000, 32'h40000000, 32'h80000001, 1'b1}, // R5
    {2'b11, 32'h80000000, 32'h00000001, 32'h80000000, 1'b1}, // R5
    {2'b11, 32'h7FFFFFFF, 32'hC0000000, 32'h7FFFFFFF, 1'b1}, // R5
    {2'b10, 32'h80000000, 32'hBFFFFFFF, 32'h80000000, 1'b1}  // R5
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   in_op = 2'b00;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_result;
  logic         out_sat;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  qsat_unit #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_sat(out_sat)
  );

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6: reset state
    check("R6 out_valid", {32'd0, out_valid}, 33'd0);
    check("R6 in_ready", {32'd0, in_ready}, 33'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table, one operation at a time (R1..R5, R7)
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][98:97], VEC[i][96:65], VEC[i][64:33]);
      @(negedge clk);
      in_valid = 1'b0;
      check("R7 valid", {32'd0, out_valid}, 33'd1);
      check($sformatf("R1-5 vec %0d", i), {out_result, out_sat}, VEC[i][32:0]);
    end
    @(negedge clk);
    check("R7 drained", {32'd0, out_valid}, 33'd0);

    // R8: back-pressure holds the result and blocks input
    out_ready = 1'b0;
    drive(VEC[1][98:97], VEC[1][96:65], VEC[1][64:33]);
    @(negedge clk);
    check("R8 ready low", {32'd0, in_ready}, 33'd0);
    drive(VEC[12][98:97], VEC[12][96:65], VEC[12][64:33]);
    @(negedge clk);
    check("R8 held", {out_result, out_sat}, VEC[1][32:0]);
    check("R8 valid held", {32'd0, out_valid}, 33'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 next after stall", {out_result, out_sat}, VEC[12][32:0]);
    check("R7 next valid", {32'd0, out_valid}, 33'd1);
    @(negedge clk);
    check("R7 empty", {32'd0, out_valid}, 33'd0);

    // R7: back-to-back throughput, one result per cycle
    drive(VEC[5][98:97], VEC[5][96:65], VEC[5][64:33]);
    @(negedge clk);
    check("R7 b2b first", {out_result, out_sat}, VEC[5][32:0]);
    drive(VEC[15][98:97], VEC[15][96:65], VEC[15][64:33]);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 b2b second", {out_result, out_sat}, VEC[15][32:0]);

    // R6: reset mid-run clears the output
    rst_n = 1'b0;
    @(negedge clk);
    check("R6 reset again", {32'd0, out_valid}, 33'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule